// File: doc/BRIEF.md
# Command Stream Opcode Decoder

This block sits behind a DMA fetch channel and turns a stream of 32-bit command words into register writes aimed at client units. Each word is taken over a valid/ready handshake. The decoder tracks whether the next word is an opcode, a payload word, or the address word of an indirect gather. Opcode words may open a run of payload words. Each payload word becomes one write of (class, register offset, data) on a held write port.

Opcode words can also raise one-cycle side-band requests: a class change, a fetch restart, an indirect gather, or a lock acquire or release. The block only signals these requests. Memory fetching and the client units lie outside it.

The controller has five states. `ST_OPCODE` decodes the next word as an opcode. `ST_INCR` emits writes to a stepping offset. `ST_FIXED` emits writes to a fixed offset. `ST_MASKED` emits writes to the offsets picked by a bit mask. `ST_GADDR` takes the gather address word.

The transitions are as follows:
- A class select with a nonzero mask goes from `ST_OPCODE` to `ST_MASKED`.
- A nonzero-count incrementing write goes to `ST_INCR`.
- A nonzero-count non-incrementing write goes to `ST_FIXED`.
- A nonzero mask write goes to `ST_MASKED`.
- A gather goes to `ST_GADDR`.
- `ST_INCR` and `ST_FIXED` return to `ST_OPCODE` on their last payload word.
- `ST_MASKED` returns to `ST_OPCODE` when no mask bit is left.
- `ST_GADDR` always returns after one word.
- Every other word keeps the controller in `ST_OPCODE`.

Top module: `cmd_stream_decoder`

## Requirements
- R1: In an opcode word, bits 31:28 hold the opcode and bits 27:16 hold the 12-bit register offset. Each write carries the current class, the offset worked out for its opcode, and its data.
- R2: Opcode 0 takes a 10-bit class from bits 15:6 and a 6-bit mask from bits 5:0.
  - It pulses `cls_valid` with that class.
  - Every later write carries this class.
  - A zero mask only changes the class.
  - A nonzero mask takes one payload word per set bit, written to offset plus bit position, lowest set bit first.
- R3: Opcode 1 takes a payload count from bits 15:0. Payload word k (from 0) is written to offset+k, modulo 4096.
- R4: Opcode 2 takes a payload count from bits 15:0. Every payload word is written to the offset itself.
- R5: Opcode 3 takes a 16-bit mask from bits 15:0. It takes one payload word per set bit, written to offset plus bit position, lowest set bit first.
- R6: Opcode 4 writes bits 15:0, zero-extended, to the offset. It takes no payload words.
- R7: Opcode 5 pulses `restart_valid`. The address is the word shifted left by 4, keeping the low 32 bits.
- R8: Opcode 6 stores insert (bit 15), type (bit 14), count (bits 13:0) and offset. The next word is the gather address whatever its contents. Once that word is taken, `gth_valid` pulses with all of these fields and decoding returns to opcode words.
- R9: Opcode 0xE with subop 0 (bits 27:24) pulses `lock_acq_valid`, and with subop 1 pulses `lock_rel_valid`. Either pulse carries index bits 7:0. Other subops and opcodes 7 to 13 and 15 produce no write and no pulse.
- R10: A payload count of zero (or a zero mask) takes no payload. The very next word is decoded as an opcode.
- R11: While a write is held and `wr_ready` is low, `in_ready` is low and the write fields stay stable. No accepted word is lost or duplicated.
- R12: Outputs for an accepted word appear on the cycle after acceptance. Side-band pulses last one cycle and at most one is raised at a time. After reset `in_ready` is high and no valid output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted this cycle when valid |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Client takes the write |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| cls_valid | output | 1 | Class change pulse |
| cls_id | output | 10 | New class |
| restart_valid | output | 1 | Fetch restart pulse |
| restart_addr | output | 32 | Restart address |
| gth_valid | output | 1 | Indirect gather pulse |
| gth_insert | output | 1 | Gather insert flag |
| gth_type | output | 1 | Gather type flag |
| gth_count | output | 14 | Gather word count |
| gth_offset | output | 12 | Gather register offset |
| gth_addr | output | 32 | Gather address word |
| lock_acq_valid | output | 1 | Lock acquire pulse |
| lock_rel_valid | output | 1 | Lock release pulse |
| lock_index | output | 8 | Lock index |

## Verification
The hardest case is payload and address words whose top bits look like valid opcodes. Decoding them as opcodes would look plausible, so the test must show they are treated as data. The stimulus feeds non-incrementing payloads of 0x5000_0000 and a gather address of 0x4000_0000, alongside zero-count and zero-mask opcodes that must hand the next word straight to opcode decoding. A second pass repeats the stream, and then a generated stream, under random write-port stalls. These stalls land on last payload words and on gather address words, where a lost or doubled word would show up at once in the behavioural model.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_INCR,
        ST_FIXED,
        ST_MASKED,
        ST_GADDR
    } dec_state_e;

    localparam logic [3:0] OP_CLASS  = 4'h0;
    localparam logic [3:0] OP_INCR   = 4'h1;
    localparam logic [3:0] OP_FIXED  = 4'h2;
    localparam logic [3:0] OP_MASKED = 4'h3;
    localparam logic [3:0] OP_IMM    = 4'h4;
    localparam logic [3:0] OP_RESTRT = 4'h5;
    localparam logic [3:0] OP_GATHER = 4'h6;
    localparam logic [3:0] OP_EXT    = 4'hE;

    localparam logic [3:0] SUB_ACQ = 4'h0;
    localparam logic [3:0] SUB_REL = 4'h1;
endpackage

// File: rtl/cmd_lsb_pick.sv
module cmd_lsb_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] pos,
    output logic [W-1:0]  rest,
    output logic          last
);
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) pos = IW'(i);
        end
        rest = bits & (bits - W'(1));
        last = (rest == '0);
    end
endmodule

// File: rtl/cmd_wr_stage.sv
module cmd_wr_stage #(
    parameter int CLS_W = 10,
    parameter int OFF_W = 12,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CLS_W-1:0] ld_class,
    input  logic [OFF_W-1:0] ld_offset,
    input  logic [DW-1:0]    ld_data,
    input  logic             wr_ready,
    output logic             wr_valid,
    output logic [CLS_W-1:0] wr_class,
    output logic [OFF_W-1:0] wr_offset,
    output logic [DW-1:0]    wr_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_class  <= '0;
            wr_offset <= '0;
            wr_data   <= '0;
        end else if (load) begin
            wr_valid  <= 1'b1;
            wr_class  <= ld_class;
            wr_offset <= ld_offset;
            wr_data   <= ld_data;
        end else if (wr_ready) begin
            wr_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_dec_pkg::*;
#(
    parameter int CLS_W  = 10,
    parameter int OFF_W  = 12,
    parameter int CNT_W  = 16,
    parameter int MASK_W = 16,
    parameter int SMSK_W = 6,
    parameter int GCNT_W = 14,
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [CLS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [31:0]       wr_data,
    output logic              cls_valid,
    output logic [CLS_W-1:0]  cls_id,
    output logic              restart_valid,
    output logic [31:0]       restart_addr,
    output logic              gth_valid,
    output logic              gth_insert,
    output logic              gth_type,
    output logic [GCNT_W-1:0] gth_count,
    output logic [OFF_W-1:0]  gth_offset,
    output logic [31:0]       gth_addr,
    output logic              lock_acq_valid,
    output logic              lock_rel_valid,
    output logic [LOCK_W-1:0] lock_index
);
    localparam int PW = $clog2(MASK_W);

    dec_state_e        state, nstate;
    logic [CLS_W-1:0]  cur_cls, n_cls;
    logic [OFF_W-1:0]  base_off, n_off;
    logic [OFF_W-1:0]  step, n_step;
    logic [CNT_W-1:0]  remain, n_remain;
    logic [MASK_W-1:0] mask, n_mask;
    logic              g_ins, g_typ, n_g_ins, n_g_typ;
    logic [GCNT_W-1:0] g_cnt, n_g_cnt;
    logic [OFF_W-1:0]  g_off, n_g_off;

    logic              fire;
    logic [3:0]        op;
    logic [OFF_W-1:0]  fld_off;
    logic [PW-1:0]     lsb_pos;
    logic [MASK_W-1:0] lsb_rest;
    logic              lsb_last;

    logic              ld;
    logic [OFF_W-1:0]  ld_off;
    logic [31:0]       ld_data;
    logic              p_cls, p_rst, p_gth, p_acq, p_rel;

    assign in_ready = !wr_valid || wr_ready;
    assign fire     = in_valid && in_ready;
    assign op       = in_data[31:28];
    assign fld_off  = in_data[16 +: OFF_W];

    cmd_lsb_pick #(.W(MASK_W)) u_pick (
        .bits (mask),
        .pos  (lsb_pos),
        .rest (lsb_rest),
        .last (lsb_last)
    );

    always_comb begin
        nstate   = state;
        n_cls    = cur_cls;
        n_off    = base_off;
        n_step   = step;
        n_remain = remain;
        n_mask   = mask;
        n_g_ins  = g_ins;
        n_g_typ  = g_typ;
        n_g_cnt  = g_cnt;
        n_g_off  = g_off;
        ld       = 1'b0;
        ld_off   = base_off;
        ld_data  = in_data;
        p_cls    = 1'b0;
        p_rst    = 1'b0;
        p_gth    = 1'b0;
        p_acq    = 1'b0;
        p_rel    = 1'b0;
        if (fire) begin
            unique case (state)
                ST_OPCODE: begin
                    unique case (op)
                        OP_CLASS: begin
                            n_cls  = in_data[6 +: CLS_W];
                            p_cls  = 1'b1;
                            n_off  = fld_off;
                            n_mask = MASK_W'(in_data[SMSK_W-1:0]);
                            if (in_data[SMSK_W-1:0] != '0) nstate = ST_MASKED;
                        end
                        OP_INCR, OP_FIXED: begin
                            n_off    = fld_off;
                            n_step   = '0;
                            n_remain = in_data[CNT_W-1:0];
                            if (in_data[CNT_W-1:0] != '0)
                                nstate = (op == OP_INCR) ? ST_INCR : ST_FIXED;
                        end
                        OP_MASKED: begin
                            n_off  = fld_off;
                            n_mask = in_data[MASK_W-1:0];
                            if (in_data[MASK_W-1:0] != '0) nstate = ST_MASKED;
                        end
                        OP_IMM: begin
                            ld      = 1'b1;
                            ld_off  = fld_off;
                            ld_data = {16'd0, in_data[15:0]};
                        end
                        OP_RESTRT: p_rst = 1'b1;
                        OP_GATHER: begin
                            n_g_ins = in_data[15];
                            n_g_typ = in_data[14];
                            n_g_cnt = in_data[GCNT_W-1:0];
                            n_g_off = fld_off;
                            nstate  = ST_GADDR;
                        end
                        OP_EXT: begin
                            p_acq = (in_data[27:24] == SUB_ACQ);
                            p_rel = (in_data[27:24] == SUB_REL);
                        end
                        default: ;
                    endcase
                end
                ST_INCR, ST_FIXED: begin
                    ld       = 1'b1;
                    ld_off   = (state == ST_INCR) ? base_off + step : base_off;
                    n_step   = step + OFF_W'(1);
                    n_remain = remain - CNT_W'(1);
                    if (remain == CNT_W'(1)) nstate = ST_OPCODE;
                end
                ST_MASKED: begin
                    ld     = 1'b1;
                    ld_off = base_off + OFF_W'(lsb_pos);
                    n_mask = lsb_rest;
                    if (lsb_last) nstate = ST_OPCODE;
                end
                ST_GADDR: begin
                    p_gth  = 1'b1;
                    nstate = ST_OPCODE;
                end
                default: nstate = ST_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OPCODE;
            cur_cls  <= '0;
            base_off <= '0;
            step     <= '0;
            remain   <= '0;
            mask     <= '0;
            g_ins    <= 1'b0;
            g_typ    <= 1'b0;
            g_cnt    <= '0;
            g_off    <= '0;
        end else begin
            state    <= nstate;
            cur_cls  <= n_cls;
            base_off <= n_off;
            step     <= n_step;
            remain   <= n_remain;
            mask     <= n_mask;
            g_ins    <= n_g_ins;
            g_typ    <= n_g_typ;
            g_cnt    <= n_g_cnt;
            g_off    <= n_g_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_valid      <= 1'b0;
            cls_id         <= '0;
            restart_valid  <= 1'b0;
            restart_addr   <= '0;
            gth_valid      <= 1'b0;
            gth_insert     <= 1'b0;
            gth_type       <= 1'b0;
            gth_count      <= '0;
            gth_offset     <= '0;
            gth_addr       <= '0;
            lock_acq_valid <= 1'b0;
            lock_rel_valid <= 1'b0;
            lock_index     <= '0;
        end else begin
            cls_valid      <= p_cls;
            restart_valid  <= p_rst;
            gth_valid      <= p_gth;
            lock_acq_valid <= p_acq;
            lock_rel_valid <= p_rel;
            if (p_cls) cls_id <= n_cls;
            if (p_rst) restart_addr <= {in_data[27:0], 4'h0};
            if (p_gth) begin
                gth_insert <= g_ins;
                gth_type   <= g_typ;
                gth_count  <= g_cnt;
                gth_offset <= g_off;
                gth_addr   <= in_data;
            end
            if (p_acq || p_rel) lock_index <= in_data[LOCK_W-1:0];
        end
    end

    cmd_wr_stage #(.CLS_W(CLS_W), .OFF_W(OFF_W), .DW(32)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .ld_class  (cur_cls),
        .ld_offset (ld_off),
        .ld_data   (ld_data),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_class  (wr_class),
        .wr_offset (wr_offset),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
    parameter int CLS_W  = 10,
    parameter int OFF_W  = 12,
    parameter int LOCK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [CLS_W-1:0] wr_class,
    input logic [OFF_W-1:0] wr_offset,
    input logic [31:0]      wr_data,
    input logic             cls_valid,
    input logic             restart_valid,
    input logic [31:0]      restart_addr,
    input logic             gth_valid,
    input logic             lock_acq_valid,
    input logic             lock_rel_valid
);
    a_r11_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);

    a_r11_held_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset)
                                     && $stable(wr_data) && $stable(wr_class)));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_valid, restart_valid, gth_valid, lock_acq_valid, lock_rel_valid}));

    a_r7_restart_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> (restart_addr[3:0] == 4'h0));

    a_r8_gather_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        gth_valid |-> $past(in_valid && in_ready));

    a_r12_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        gth_valid |=> !gth_valid);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_class       (wr_class),
    .wr_offset      (wr_offset),
    .wr_data        (wr_data),
    .cls_valid      (cls_valid),
    .restart_valid  (restart_valid),
    .restart_addr   (restart_addr),
    .gth_valid      (gth_valid),
    .lock_acq_valid (lock_acq_valid),
    .lock_rel_valid (lock_rel_valid)
);

// File: tb/cmd_stream_decoder_tb.sv
module cmd_stream_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        cls_valid;
    logic [9:0]  cls_id;
    logic        restart_valid;
    logic [31:0] restart_addr;
    logic        gth_valid, gth_insert, gth_type;
    logic [13:0] gth_count;
    logic [11:0] gth_offset;
    logic [31:0] gth_addr;
    logic        lock_acq_valid, lock_rel_valid;
    logic [7:0]  lock_index;

    always #5 clk = ~clk;

    cmd_stream_decoder u_dut (.*);

    int errors = 0, checks = 0;
    bit bp = 0, done = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit [53:0]   wq[$];
    string       wt[$];
    int          ms = 0;
    int          rem = 0, idx = 0;
    bit [15:0]   mm;
    bit [11:0]   mo;
    bit [9:0]    mc = 0;
    bit          gi, gy;
    bit [13:0]   gc;
    bit [11:0]   go;
    string       tag, ptag = "";
    bit          e_cls, e_rst, e_gth, e_acq, e_rel;
    bit [9:0]    e_cid;
    bit [31:0]   e_raddr, e_gaddr;
    bit [7:0]    e_lidx;

    task automatic push(bit [11:0] o, bit [31:0] d, string t);
        wq.push_back({mc, o, d});
        wt.push_back(t);
    endtask

    task automatic model(bit [31:0] w);
        case (ms)
            0: begin
                tag = (ptag != "") ? ptag : "";
                ptag = "";
                case (w[31:28])
                    4'h0: begin
                        mc = w[15:6]; e_cls = 1; e_cid = w[15:6];
                        mo = w[27:16]; mm = {10'd0, w[5:0]};
                        if (mm != 0) ms = 3; else ptag = "R10";
                    end
                    4'h1, 4'h2: begin
                        mo = w[27:16]; rem = w[15:0]; idx = 0;
                        if (rem != 0) ms = (w[31:28] == 1) ? 1 : 2; else ptag = "R10";
                    end
                    4'h3: begin
                        mo = w[27:16]; mm = w[15:0];
                        if (mm != 0) ms = 4; else ptag = "R10";
                    end
                    4'h4: push(w[27:16], {16'd0, w[15:0]}, (tag != "") ? tag : "R6");
                    4'h5: begin e_rst = 1; e_raddr = w << 4; end
                    4'h6: begin
                        gi = w[15]; gy = w[14]; gc = w[13:0]; go = w[27:16]; ms = 5;
                    end
                    4'hE: begin
                        if (w[27:24] == 0) begin e_acq = 1; e_lidx = w[7:0]; end
                        if (w[27:24] == 1) begin e_rel = 1; e_lidx = w[7:0]; end
                    end
                    default: ;
                endcase
            end
            1, 2: begin
                push((ms == 1) ? mo + 12'(idx) : mo, w, (ms == 1) ? "R3" : "R4");
                idx++; rem--;
                if (rem == 0) ms = 0;
            end
            3, 4: begin
                int p = 0;
                for (int i = 15; i >= 0; i--) if (mm[i]) p = i;
                push(mo + 12'(p), w, (ms == 3) ? "R2" : "R5");
                mm[p] = 1'b0;
                if (mm == 0) ms = 0;
            end
            5: begin e_gth = 1; e_gaddr = w; ms = 0; end
            default: ms = 0;
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(in_ready === 1'b1, "R12 reset ready", 64'(in_ready), 1);
            chk(wr_valid === 1'b0 && {cls_valid, restart_valid, gth_valid,
                lock_acq_valid, lock_rel_valid} === 5'b0, "R12 reset valids",
                64'({wr_valid, cls_valid, restart_valid, gth_valid}), 0);
        end else begin
            chk(in_ready === (wq.size() == 0 || wr_ready), "R11 in_ready",
                64'(in_ready), 64'(wq.size() == 0 || wr_ready));
            chk(wr_valid === (wq.size() != 0), "R11 wr_valid", 64'(wr_valid), 64'(wq.size() != 0));
            if (wq.size() != 0 && wr_valid) begin
                chk(wr_offset === wq[0][43:32], "R1 offset", 64'(wr_offset), 64'(wq[0][43:32]));
                chk(wr_class === wq[0][53:44], "R2 class", 64'(wr_class), 64'(wq[0][53:44]));
                chk(wr_data === wq[0][31:0], wt[0], 64'(wr_data), 64'(wq[0][31:0]));
            end
            chk($countones({cls_valid, restart_valid, gth_valid, lock_acq_valid,
                lock_rel_valid}) <= 1, "R12 one pulse", 64'(cls_valid), 0);
            chk(cls_valid === e_cls, "R2 cls_valid", 64'(cls_valid), 64'(e_cls));
            if (e_cls) chk(cls_id === e_cid, "R2 cls_id", 64'(cls_id), 64'(e_cid));
            chk(restart_valid === e_rst, "R7 restart_valid", 64'(restart_valid), 64'(e_rst));
            if (e_rst) chk(restart_addr === e_raddr, "R7 addr", 64'(restart_addr), 64'(e_raddr));
            chk(gth_valid === e_gth, "R8 gth_valid", 64'(gth_valid), 64'(e_gth));
            if (e_gth)
                chk({gth_insert, gth_type, gth_count, gth_offset, gth_addr} ===
                    {gi, gy, gc, go, e_gaddr}, "R8 fields",
                    64'({gth_insert, gth_type, gth_count, gth_offset, gth_addr}),
                    64'({gi, gy, gc, go, e_gaddr}));
            chk(lock_acq_valid === e_acq && lock_rel_valid === e_rel, "R9 lock pulses",
                64'({lock_acq_valid, lock_rel_valid}), 64'({e_acq, e_rel}));
            if (e_acq || e_rel) chk(lock_index === e_lidx, "R9 index", 64'(lock_index), 64'(e_lidx));
            // advance model to the state after the next edge
            e_cls = 0; e_rst = 0; e_gth = 0; e_acq = 0; e_rel = 0;
            if (wr_valid && wr_ready && wq.size() != 0) begin
                void'(wq.pop_front());
                void'(wt.pop_front());
            end
            if (in_valid && in_ready) model(in_data);
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            wr_ready = bp ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    task automatic send(bit [31:0] w);
        bit acc;
        in_valid = 1'b1; in_data = w;
        do begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic directed();
        send({4'h0, 12'h000, 10'h2A5, 6'b0});                 // R2 zero mask
        send({4'h0, 12'h010, 10'h055, 6'b101001});            // R2 masked class
        send(32'hA1); send(32'hA2); send(32'hA3);
        send({4'h1, 12'h020, 16'd3});                         // R3
        send(32'hB0); send(32'hB1); send(32'hB2);
        send({4'h1, 12'hFFE, 16'd3});                         // R3 wrap
        send(32'hC0); send(32'hC1); send(32'hC2);
        send({4'h1, 12'h005, 16'd0});                         // R10
        send({4'h4, 12'h033, 16'hBEEF});                      // R6 after zero count
        send({4'h2, 12'h044, 16'd2});                         // R4
        send(32'h5000_0000); send(32'h5000_0001);
        send({4'h3, 12'h100, 16'h8011});                      // R5
        send(32'hD0); send(32'hD1); send(32'hD2);
        send({4'h3, 12'h001, 16'h0});                         // R10 zero mask
        send({4'h4, 12'h034, 16'h1234});
        send(32'h5123_4567);                                  // R7
        send({4'h6, 12'hABC, 1'b1, 1'b0, 14'h1234});          // R8
        send(32'h4000_0000);
        send(32'hE000_0007); send(32'hE100_0042);             // R9
        send(32'hE200_0011); send(32'h7FFF_FFFF);
        send(32'hF000_0000); send(32'hD123_4567);
        send({4'h4, 12'h035, 16'h0001});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        directed();
        bp = 1;
        directed();
        for (int n = 0; n < 400; n++) begin
            bit [31:0] w = $urandom;
            if (w[31:28] == 4'h1 || w[31:28] == 4'h2) w[15:0] = w[15:0] & 16'h7;
            send(w);
        end
        bp = 0;
        send({4'h4, 12'h0, 16'h0});
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(wq.size() == 0 && !wr_valid, "R11 drained", 64'(wq.size()), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule